// File: doc/BRIEF.md
# Load Result Delay-Slot Pipeline

This block is the execute and writeback path of a small processor core in which every instruction issues in one clock cycle, but a load's result lands in its destination register only after a fixed number of delay slots. There is no hardware interlock. An instruction that reads a register while a load to it is still in flight gets the value the register held before the load. The schedule must cover the gap, either with single idle instructions or with one multi-cycle idle instruction.

Each cycle the block takes one issue slot. The slot holds an opcode, destination and source register indices, an idle-cycle count, and memory read data for a load. A load is captured into a four-stage shift pipeline and drives the load write port when it leaves the last stage. A move reads the source register through a read port and writes the destination at the end of its own issue cycle. A multi-cycle idle instruction starts a countdown. While the countdown runs, the block raises `busy` and ignores the issue slot, but loads already in the pipeline keep advancing.

The issue controller has two states. ST_ISSUE accepts one instruction per cycle. ST_IDLE holds issue off while the countdown is non-zero. There are two transitions:
- ST_ISSUE to ST_IDLE when an idle instruction with a count above one is accepted.
- ST_IDLE to ST_ISSUE when the remaining count reaches one.

Top module: `load_delay_pipe`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `ld_we` and `mv_we` are all low in the first cycle following reset.
- R2: A move (`issue_op` = 2'b10) accepted in cycle t drives `mv_we` high in cycle t, with `mv_waddr` = `issue_dst` and `mv_wdata` = `rf_rdata`. Here `rf_raddr` = `issue_src`, so the destination holds the source value from cycle t+1.
- R3: A load (`issue_op` = 2'b01) accepted in cycle t drives `ld_we` high in cycle t+4 and in no cycle from t+1 to t+3. The write carries the `issue_dst` and `mem_rdata` that were captured in cycle t.
- R4: There is no interlock. A move that reads a load's destination in cycles t+1 to t+4 gets the old contents. A move that reads it in cycle t+5 gets the loaded value.
- R5: An idle instruction (`issue_op` = 2'b00) with count n, for 2 ≤ n ≤ 15, holds `busy` high for exactly the n-1 cycles after its issue cycle. The next instruction is accepted n cycles after the idle instruction. A count of 0 or 1 idles for only its own cycle. A count of 4 takes the same cycles as four single idle instructions.
- R6: While `busy` is high, the issue slot is ignored. No move write occurs, and no load enters the pipeline.
- R7: Loads in flight keep advancing while `busy` is high.
- R8: If a maturing load and a move target the same register in the same cycle, only the load writes (`mv_we` low). The register then holds the load data.
- R9: Loads accepted in consecutive cycles each mature four cycles later, in issue order, with their own index and data.
- R10: Opcode 2'b11 is reserved. It acts as a single-cycle idle instruction whatever its count field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue slot holds an instruction |
| issue_op | input | 2 | 00 idle, 01 load, 10 move, 11 reserved |
| issue_dst | input | IDX_W | Destination register index |
| issue_src | input | IDX_W | Source register index of a move |
| nop_cycles | input | CNT_W | Idle-cycle count of an idle instruction |
| mem_rdata | input | DATA_W | Memory data of a load in its issue cycle |
| busy | output | 1 | Multi-cycle idle countdown active |
| rf_raddr | output | IDX_W | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data |
| ld_we | output | 1 | Matured load write enable |
| ld_waddr | output | IDX_W | Matured load destination |
| ld_wdata | output | DATA_W | Matured load data |
| mv_we | output | 1 | Move write enable |
| mv_waddr | output | IDX_W | Move destination |
| mv_wdata | output | DATA_W | Move data |

## Verification
The hardest cases to reach are those where the pipeline and the countdown interact. These are a load maturing while `busy` holds issue off, and a move colliding with a maturing load on the same register.

The bench reaches them by sweeping two distances:
- the distance between a load and a dependent move, from 1 to 6 cycles;
- the idle count, from 0 to 6.

During every busy cycle the bench offers moves and loads that must be dropped. It then lines up a load and a move to the same register exactly four cycles apart. Expected register contents follow from the cycle arithmetic of R3 to R5.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_LOAD = 2'b01,
        OP_MOVE = 2'b10,
        OP_RSVD = 2'b11
    } ldp_op_e;

    typedef enum logic {
        ST_ISSUE = 1'b0,
        ST_IDLE  = 1'b1
    } ldp_state_e;
endpackage

// File: rtl/ldp_issue_fsm.sv
module ldp_issue_fsm
    import ldp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  ldp_op_e          issue_op,
    input  logic [CNT_W-1:0] nop_cycles,
    output logic             busy,
    output logic             accept_load,
    output logic             accept_move
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ldp_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic             long_nop;

    assign long_nop = issue_valid && (issue_op == OP_NOP) && (nop_cycles > ONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ISSUE;
        else     state_q <= state_d;
    end

    // remaining idle cycles after the issue cycle
    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (state_q == ST_ISSUE && long_nop)
            remain_q <= nop_cycles - ONE;
        else if (state_q == ST_IDLE)
            remain_q <= remain_q - ONE;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ISSUE: if (long_nop) state_d = ST_IDLE;
            ST_IDLE:  if (remain_q == ONE) state_d = ST_ISSUE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        accept_load = 1'b0;
        accept_move = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                accept_load = issue_valid && (issue_op == OP_LOAD);
                accept_move = issue_valid && (issue_op == OP_MOVE);
            end
            ST_IDLE: busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/ldp_shift_pipe.sv
module ldp_shift_pipe #(
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data
);
    logic              vld_q  [DEPTH];
    logic [IDX_W-1:0]  idx_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) vld_q[s] <= 1'b0;
                else     vld_q[s] <= in_vld;
                idx_q[s]  <= in_idx;
                data_q[s] <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) vld_q[s] <= 1'b0;
                else     vld_q[s] <= vld_q[s-1];
                idx_q[s]  <= idx_q[s-1];
                data_q[s] <= data_q[s-1];
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_idx  = idx_q[DEPTH-1];
    assign out_data = data_q[DEPTH-1];
endmodule

// File: rtl/ldp_wb_arb.sv
module ldp_wb_arb #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              ld_req,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              mv_req,
    input  logic [IDX_W-1:0]  mv_idx,
    input  logic [DATA_W-1:0] mv_data,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_waddr,
    output logic [DATA_W-1:0] ld_wdata,
    output logic              mv_we,
    output logic [IDX_W-1:0]  mv_waddr,
    output logic [DATA_W-1:0] mv_wdata
);
    logic clash;

    assign clash    = ld_req && mv_req && (ld_idx == mv_idx);
    assign ld_we    = ld_req;
    assign ld_waddr = ld_idx;
    assign ld_wdata = ld_data;
    assign mv_we    = mv_req && !clash;
    assign mv_waddr = mv_idx;
    assign mv_wdata = mv_data;
endmodule

// File: rtl/load_delay_pipe.sv
module load_delay_pipe
    import ldp_pkg::*;
#(
    parameter int DELAY  = 4,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [1:0]        issue_op,
    input  logic [IDX_W-1:0]  issue_dst,
    input  logic [IDX_W-1:0]  issue_src,
    input  logic [CNT_W-1:0]  nop_cycles,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_waddr,
    output logic [DATA_W-1:0] ld_wdata,
    output logic              mv_we,
    output logic [IDX_W-1:0]  mv_waddr,
    output logic [DATA_W-1:0] mv_wdata
);
    ldp_op_e           op;
    logic              acc_load, acc_move;
    logic              mat_vld;
    logic [IDX_W-1:0]  mat_idx;
    logic [DATA_W-1:0] mat_data;

    assign op       = ldp_op_e'(issue_op);
    assign rf_raddr = issue_src;

    ldp_issue_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_op    (op),
        .nop_cycles  (nop_cycles),
        .busy        (busy),
        .accept_load (acc_load),
        .accept_move (acc_move)
    );

    ldp_shift_pipe #(.DEPTH(DELAY), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (acc_load),
        .in_idx   (issue_dst),
        .in_data  (mem_rdata),
        .out_vld  (mat_vld),
        .out_idx  (mat_idx),
        .out_data (mat_data)
    );

    ldp_wb_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arb (
        .ld_req   (mat_vld),
        .ld_idx   (mat_idx),
        .ld_data  (mat_data),
        .mv_req   (acc_move),
        .mv_idx   (issue_dst),
        .mv_data  (rf_rdata),
        .ld_we    (ld_we),
        .ld_waddr (ld_waddr),
        .ld_wdata (ld_wdata),
        .mv_we    (mv_we),
        .mv_waddr (mv_waddr),
        .mv_wdata (mv_wdata)
    );
endmodule

// File: rtl/ldp_checker.sv
module ldp_checker #(
    parameter int DELAY = 4,
    parameter int IDX_W = 4,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic [1:0]       issue_op,
    input logic [CNT_W-1:0] nop_cycles,
    input logic             busy,
    input logic             ld_we,
    input logic [IDX_W-1:0] ld_waddr,
    input logic             mv_we,
    input logic [IDX_W-1:0] mv_waddr
);
    logic             load_in, nop_in;
    logic [DELAY-1:0] hist_q;

    assign load_in = !rst && issue_valid && !busy && issue_op == 2'b01;
    assign nop_in  = !rst && issue_valid && !busy && issue_op == 2'b00;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[DELAY-2:0], load_in};
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!busy && !ld_we)); // R1
    AST_LOAD_MATURES: assert property (@(posedge clk) disable iff (rst) hist_q[DELAY-1] |-> ld_we); // R3
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst) ld_we |-> hist_q[DELAY-1]); // R3
    AST_LONG_NOP_BUSY: assert property (@(posedge clk) disable iff (rst) (nop_in && nop_cycles > CNT_W'(1)) |=> busy); // R5
    AST_SHORT_NOP_FREE: assert property (@(posedge clk) disable iff (rst) (nop_in && nop_cycles <= CNT_W'(1)) |=> !busy); // R5
    AST_BUSY_NO_MOVE: assert property (@(posedge clk) disable iff (rst) busy |-> !mv_we); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) (ld_we && mv_we) |-> (ld_waddr != mv_waddr)); // R8
endmodule

bind load_delay_pipe ldp_checker #(.DELAY(DELAY), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .nop_cycles  (nop_cycles),
    .busy        (busy),
    .ld_we       (ld_we),
    .ld_waddr    (ld_waddr),
    .mv_we       (mv_we),
    .mv_waddr    (mv_waddr)
);

// File: tb/load_delay_pipe_tb.sv
module load_delay_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 4, DATA_W = 32, CNT_W = 4;

    logic              clk = 1'b0, rst = 1'b1;
    logic              issue_valid = 1'b0;
    logic [1:0]        issue_op = 2'b00;
    logic [IDX_W-1:0]  issue_dst = '0, issue_src = '0;
    logic [CNT_W-1:0]  nop_cycles = '0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              busy, ld_we, mv_we;
    logic [IDX_W-1:0]  rf_raddr, ld_waddr, mv_waddr;
    logic [DATA_W-1:0] rf_rdata, ld_wdata, mv_wdata;
    logic [DATA_W-1:0] rf [16];

    int tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_delay_pipe u_dut (.*);

    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) begin
        if (mv_we) rf[mv_waddr] <= mv_wdata;
        if (ld_we) rf[ld_waddr] <= ld_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input int dst, input int src,
                         input int cnt, input logic [31:0] d);
        issue_valid = v; issue_op = op; issue_dst = IDX_W'(dst); issue_src = IDX_W'(src);
        nop_cycles = CNT_W'(cnt); mem_rdata = d;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin drive(0, 2'b00, 0, 0, 0, 0); tick(); end
    endtask

    task automatic set_reg(input int r, input logic [31:0] v);
        drive(1, 2'b01, r, 0, 0, v); tick(); idle(5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check("R1 busy", 32'(busy), 0);
        check("R1 ld_we", 32'(ld_we), 0);
        check("R1 mv_we", 32'(mv_we), 0);

        // R2
        set_reg(1, 32'hC0DE_0001);
        drive(1, 2'b10, 6, 1, 0, 0);
        check("R2 mv_we", 32'(mv_we), 1);
        check("R2 mv_waddr", 32'(mv_waddr), 6);
        check("R2 mv_wdata", mv_wdata, 32'hC0DE_0001);
        tick(); idle(1);
        check("R2 reg", rf[6], 32'hC0DE_0001);

        // R3, R4: load-to-move distance sweep
        for (int d = 1; d <= 6; d++) begin
            set_reg(2, 32'h1000_0000 + d);
            drive(1, 2'b01, 2, 0, 0, 32'hA500_0000 + d); tick();
            for (int k = 1; k < d; k++) begin
                drive(0, 2'b00, 0, 0, 0, 0);
                check("R3 ld_we timing", 32'(ld_we), 32'(k == 4));
                tick();
            end
            drive(1, 2'b10, 5, 2, 0, 0);
            check("R3 ld_we timing", 32'(ld_we), 32'(d == 4));
            tick(); idle(5);
            check("R4 move sees", rf[5], (d <= 4) ? 32'h1000_0000 + d : 32'hA500_0000 + d);
            check("R3 load data", rf[2], 32'hA500_0000 + d);
        end

        // R5, R6: idle count sweep with dropped issue
        set_reg(7, 32'h7777_0000);
        for (int n = 0; n <= 6; n++) begin
            int nb;
            nb = (n < 1) ? 0 : n - 1;
            drive(1, 2'b00, 0, 0, n, 0); tick();
            for (int k = 1; k <= nb + 1; k++) begin
                if (k <= nb) begin
                    if (k % 2 == 1) drive(1, 2'b10, 7, 1, 0, 0);
                    else            drive(1, 2'b01, 7, 0, 0, 32'hDEAD_0000 + k);
                    check("R6 no move while busy", 32'(mv_we), 0);
                end else drive(0, 2'b00, 0, 0, 0, 0);
                check("R5 busy window", 32'(busy), 32'(k <= nb));
                tick();
            end
            idle(5);
            check("R6 reg untouched", rf[7], 32'h7777_0000);
        end

        // R10 reserved opcode
        drive(1, 2'b11, 0, 0, 9, 0); tick();
        drive(0, 2'b00, 0, 0, 0, 0);
        check("R10 reserved not busy", 32'(busy), 0);
        idle(2);

        // R7: load advances during idle 4 (and idle 3 is one short)
        for (int n = 3; n <= 4; n++) begin
            set_reg(3, 32'h3333_0000 + n);
            drive(1, 2'b01, 3, 0, 0, 32'hBEEF_0000 + n); tick();
            drive(1, 2'b00, 0, 0, n, 0); tick();
            idle(n - 1);
            drive(1, 2'b10, 8, 3, 0, 0); tick(); idle(5);
            check("R7 load during busy", rf[8], (n == 4) ? 32'hBEEF_0004 : 32'h3333_0003);
        end

        // R8 collision
        set_reg(4, 32'h4444_4444);
        drive(1, 2'b01, 4, 0, 0, 32'h5A5A_0008); tick();
        idle(3);
        drive(1, 2'b10, 4, 1, 0, 0);
        check("R8 ld_we", 32'(ld_we), 1);
        check("R8 mv_we blocked", 32'(mv_we), 0);
        tick(); idle(1);
        check("R8 reg", rf[4], 32'h5A5A_0008);

        // R9 back-to-back
        for (int i = 0; i < 4; i++) begin drive(1, 2'b01, 9 + i, 0, 0, 32'h9900_0000 + i); tick(); end
        for (int i = 0; i < 4; i++) begin
            drive(0, 2'b00, 0, 0, 0, 0);
            check("R9 order addr", 32'(ld_waddr), 32'(9 + i));
            check("R9 order data", ld_wdata, 32'h9900_0000 + i);
            tick();
        end
        idle(1);
        check("R9 final", rf[12], 32'h9900_0003);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule